// File: doc/BRIEF.md
# I2C Slave Register Port

This block lets an external I2C controller read and write a bank of 128 eight-bit registers. It oversamples the SCL and SDA lines with a fast system clock and finds START and STOP conditions. It answers only to a 7-bit device address whose upper nibble is fixed at 0010 and whose three low bits come from strap inputs. The block never drives SDA high. It pulls SDA low only through an active-low output enable, and the board's pull-up does the rest.

A write transfer carries a register pointer byte first, then any number of data bytes. Each data byte lands in the register the pointer selects, and the pointer then steps forward. A read transfer cannot carry a pointer. It returns bytes from wherever the last write left the pointer, so a controller first sends a write that holds only the pointer byte, ends it with a STOP or a repeated START, and then reads. The top eight registers return fixed values and ignore writes.

Top module: `i2creg_port`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. The block only pulls SDA low while the synchronized SCL is low.
- R2: The first byte after a START is a 7-bit address, MSB first, followed by a direction bit (1 = read, 0 = write). The address matches only when it equals 0010 followed by strap_addr[2], strap_addr[1] and strap_addr[0].
- R3: After an address that does not match, SDA stays released until the next START or STOP, and no register changes.
- R4: In a write, the byte after the address loads the pointer (its low 7 bits). Each later byte is stored in the register the pointer selects.
- R5: The pointer advances by one after every register byte, whether read or written, and wraps from 127 to 0.
- R6: The block pulls SDA low during the ninth clock after every byte it receives: the address byte, the pointer byte and each data byte.
- R7: In a read, the block shifts out the register at the pointer, MSB first, and samples the controller's bit on each ninth clock. A 1 on that bit (NACK) makes the block release SDA and stop sending.
- R8: A write that carries only a pointer byte and then ends with a STOP keeps the pointer for the next read transfer.
- R9: A repeated START at any point, including in the middle of a byte, restarts address decoding. A partly received data byte is then discarded.
- R10: Registers 0 to 119 are writable and reset to 0. Registers 120 to 127 read as 8'hFF XOR the register number. Writes to registers 120 to 127 are acknowledged but have no effect.
- R11: After reset, SDA is released (sda_oe_n = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the pad |
| sda_i | input | 1 | I2C data line as seen on the pad |
| strap_addr | input | 3 | Low three bits of the device address |
| sda_oe_n | output | 1 | Active-low enable of the SDA low driver |

## Verification
Most wrong internal states show up on the bus within one byte. A wrong bit count or a wrong phase moves the acknowledge off the ninth clock, and the controller reads a NACK or a corrupted bit at the next sample point. A pointer that is off by one, or that fails to wrap, does not show until a later read, where the returned bytes shift to a neighbouring register. The bench therefore follows each write with reads that cross the writable-to-fixed boundary and the 127-to-0 wrap. An address-match error shows immediately as an acknowledge on a foreign address, or as a missing one on the strapped address.

// File: rtl/i2creg_pkg.sv
package i2creg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RXEND, ST_ACK, ST_TX, ST_RACK, ST_SKIP
  } slv_state_t;

  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} rx_kind_t;

  localparam logic [3:0] DEV_ID_HI = 4'b0010;
endpackage

// File: rtl/i2creg_bus_sync.sv
module i2creg_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES:0] scl_pipe;
  logic [STAGES:0] sda_pipe;
  logic            scl_d;
  logic            sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign scl_d     = scl_pipe[STAGES];
  assign sda_s     = sda_pipe[STAGES-1];
  assign sda_d     = sda_pipe[STAGES];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2creg_regfile.sv
module i2creg_regfile #(
  parameter int DEPTH   = 128,
  parameter int DW      = 8,
  parameter int RO_BASE = 120,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [RO_BASE*DW-1:0] flat;
  logic [DW-1:0]         rw_val;
  logic [DW-1:0]         ro_val;
  logic                  rd_ro;

  for (genvar g = 0; g < RO_BASE; g++) begin : g_reg
    logic          en;
    logic [DW-1:0] q;
    assign en = wr_en && (int'(wr_addr) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wr_data;
    end
    assign flat[g*DW +: DW] = q;
  end

  always_comb begin
    rd_ro  = int'(rd_addr) >= RO_BASE;
    rw_val = rd_ro ? '0 : flat[int'(rd_addr)*DW +: DW];
    ro_val = {DW{1'b1}} ^ DW'(rd_addr);
    rd_data = rd_ro ? ro_val : rw_val;
  end

  // R10: a write into the fixed window leaves every stored register unchanged
  assert_ro_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_addr) >= RO_BASE) |=> $stable(flat));
endmodule

// File: rtl/i2creg_engine.sv
module i2creg_engine
  import i2creg_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [2:0]    strap_addr,
  input  logic [7:0]    rd_data,
  output logic          sda_oe_n,
  output logic          wr_en,
  output logic [AW-1:0] ptr,
  output logic [7:0]    wr_data
);
  slv_state_t state, state_nx;
  rx_kind_t   kind, kind_nx;
  logic       rd_mode, rd_mode_nx;
  logic [2:0] cnt, cnt_nx;
  logic [7:0] shreg, shreg_nx;
  logic [AW-1:0] ptr_nx;
  logic       oe_n_nx;
  logic       acked, acked_nx;
  logic       ptr_load;

  always_comb begin
    state_nx   = state;
    kind_nx    = kind;
    rd_mode_nx = rd_mode;
    cnt_nx     = cnt;
    shreg_nx   = shreg;
    ptr_nx     = ptr;
    oe_n_nx    = sda_oe_n;
    acked_nx   = acked;
    wr_en      = 1'b0;
    ptr_load   = 1'b0;
    if (stop_det) begin
      state_nx = ST_IDLE;
      oe_n_nx  = 1'b1;
    end else if (start_det) begin
      state_nx = ST_RX;
      kind_nx  = K_ADDR;
      cnt_nx   = '0;
      oe_n_nx  = 1'b1;
    end else begin
      unique case (state)
        ST_RX: if (scl_rise) begin
          shreg_nx = {shreg[6:0], sda_s};
          cnt_nx   = cnt + 3'd1;
          if (cnt == 3'd7) state_nx = ST_RXEND;
        end
        ST_RXEND: if (scl_fall) begin
          state_nx = ST_ACK;
          oe_n_nx  = 1'b0;
          unique case (kind)
            K_ADDR: begin
              if (shreg[7:1] == {DEV_ID_HI, strap_addr}) begin
                rd_mode_nx = shreg[0];
                kind_nx    = K_PTR;
              end else begin
                state_nx = ST_SKIP;
                oe_n_nx  = 1'b1;
              end
            end
            K_PTR: begin
              ptr_nx   = shreg[AW-1:0];
              ptr_load = 1'b1;
              kind_nx  = K_DATA;
            end
            default: begin
              wr_en  = 1'b1;
              ptr_nx = ptr + AW'(1);
            end
          endcase
        end
        ST_ACK: if (scl_fall) begin
          cnt_nx = '0;
          if (rd_mode) begin
            shreg_nx = rd_data;
            ptr_nx   = ptr + AW'(1);
            oe_n_nx  = rd_data[7];
            state_nx = ST_TX;
          end else begin
            oe_n_nx  = 1'b1;
            state_nx = ST_RX;
          end
        end
        ST_TX: if (scl_fall) begin
          cnt_nx = cnt + 3'd1;
          if (cnt == 3'd7) begin
            oe_n_nx  = 1'b1;
            acked_nx = 1'b0;
            state_nx = ST_RACK;
          end else begin
            shreg_nx = {shreg[6:0], 1'b0};
            oe_n_nx  = shreg[6];
          end
        end
        ST_RACK: begin
          if (scl_rise) acked_nx = ~sda_s;
          if (scl_fall) begin
            if (acked) begin
              shreg_nx = rd_data;
              ptr_nx   = ptr + AW'(1);
              oe_n_nx  = rd_data[7];
              cnt_nx   = '0;
              state_nx = ST_TX;
            end else begin
              state_nx = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      kind     <= K_ADDR;
      rd_mode  <= 1'b0;
      cnt      <= '0;
      shreg    <= '0;
      ptr      <= '0;
      sda_oe_n <= 1'b1;
      acked    <= 1'b0;
    end else begin
      state    <= state_nx;
      kind     <= kind_nx;
      rd_mode  <= rd_mode_nx;
      cnt      <= cnt_nx;
      shreg    <= shreg_nx;
      ptr      <= ptr_nx;
      sda_oe_n <= oe_n_nx;
      acked    <= acked_nx;
    end
  end

  assign wr_data = shreg;

  // R1: the low driver only switches on while SCL is low
  assert_drive_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_n) |-> !scl_s);
  // R6: the acknowledge phase always holds SDA low
  assert_ack_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACK) |-> !sda_oe_n);
  // R7: the controller's acknowledge slot is never driven by the block
  assert_rack_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RACK) |-> sda_oe_n);
  // R3: idle and skip states keep SDA released
  assert_skip_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_SKIP) |-> sda_oe_n);
  // R5: apart from a pointer load the pointer only moves by one
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ptr != $past(ptr)) && !$past(ptr_load)) |-> (ptr == $past(ptr) + AW'(1)));
endmodule

// File: rtl/i2creg_port.sv
module i2creg_port #(
  parameter int REG_COUNT   = 128,
  parameter int RO_BASE     = 120,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_addr,
  output logic       sda_oe_n
);
  localparam int AW = $clog2(REG_COUNT);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          wr_en;
  logic [AW-1:0] ptr;
  logic [7:0]    wr_data;
  logic [7:0]    rd_data;

  i2creg_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2creg_engine #(.AW(AW)) eng_i (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .strap_addr(strap_addr), .rd_data(rd_data),
    .sda_oe_n(sda_oe_n), .wr_en(wr_en), .ptr(ptr), .wr_data(wr_data)
  );

  i2creg_regfile #(.DEPTH(REG_COUNT), .DW(8), .RO_BASE(RO_BASE)) rf_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr),
    .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data)
  );
endmodule

// File: tb/i2creg_port_tb.sv
module i2creg_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] strap = 3'b011;
  logic sda_oe_n;
  logic sda_line;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs_val;
  event       obs_ev;

  always #2 clk = ~clk;

  assign sda_line = sda_m & sda_oe_n;

  i2creg_port dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_addr(strap), .sda_oe_n(sda_oe_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (10) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input bit b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, input bit exp_ack, input string tag);
    bit a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    check(a == !exp_ack, tag, a, !exp_ack);
  endtask

  task automatic push_exp(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic recv_byte(input bit nack);
    bit b;
    logic [7:0] v;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      get_bit(b);
      v = {v[6:0], b};
    end
    obs_val = v;
    -> obs_ev;
    put_bit(nack);
  endtask

  // scoreboard monitor: compares each received byte against the queue head
  initial begin
    forever begin
      @(obs_ev);
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected byte", obs_val, 0);
      end else begin
        check(obs_val == exp_q[0], tag_q[0], obs_val, exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check(sda_oe_n == 1'b1, "R11 reset release", sda_oe_n, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 R6 R4: burst write to 0x10..0x12
    bus_start();
    send_byte(8'h26, 1, "R2 address ack");
    send_byte(8'h10, 1, "R6 pointer ack");
    send_byte(8'hA5, 1, "R4 data ack 0");
    send_byte(8'h3C, 1, "R4 data ack 1");
    send_byte(8'h7E, 1, "R6 data ack 2");
    bus_stop();

    // R8: pointer-only write then a separate read; R7 R5 burst
    bus_start(); send_byte(8'h26, 1, "R8 address"); send_byte(8'h10, 1, "R8 pointer"); bus_stop();
    bus_start(); send_byte(8'h27, 1, "R2 read address ack");
    push_exp(8'hA5, "R8 R7 byte 0");
    push_exp(8'h3C, "R5 byte 1");
    push_exp(8'h7E, "R5 byte 2");
    recv_byte(0); recv_byte(0); recv_byte(1);
    wq();
    check(sda_oe_n == 1'b1, "R7 release after NACK", sda_oe_n, 1);
    bus_stop();

    // R3: foreign address is ignored, nothing written
    bus_start();
    send_byte(8'h24, 0, "R3 no ack on address");
    send_byte(8'h10, 0, "R3 no ack on later byte");
    send_byte(8'hFF, 0, "R3 no ack on data");
    bus_stop();
    bus_start(); send_byte(8'h26, 1, "R3 addr"); send_byte(8'h10, 1, "R3 ptr"); bus_stop();
    bus_start(); send_byte(8'h27, 1, "R3 read addr");
    push_exp(8'hA5, "R3 register unchanged");
    recv_byte(1); bus_stop();

    // R10 R5: writes into fixed window are acked, wrap reaches register 0
    bus_start();
    send_byte(8'h26, 1, "R10 addr");
    send_byte(8'h7E, 1, "R10 ptr");
    send_byte(8'h11, 1, "R10 ack on fixed reg 126");
    send_byte(8'h22, 1, "R10 ack on fixed reg 127");
    send_byte(8'h33, 1, "R5 ack after wrap");
    bus_stop();
    bus_start(); send_byte(8'h26, 1, "R10 addr2"); send_byte(8'h7D, 1, "R10 ptr2"); bus_stop();
    bus_start(); send_byte(8'h27, 1, "R10 read addr");
    push_exp(8'h82, "R10 fixed reg 125");
    push_exp(8'h81, "R10 fixed reg 126 unchanged");
    push_exp(8'h80, "R10 fixed reg 127 unchanged");
    push_exp(8'h33, "R5 wrap to reg 0");
    push_exp(8'h00, "R10 reset value reg 1");
    recv_byte(0); recv_byte(0); recv_byte(0); recv_byte(0); recv_byte(1);
    bus_stop();

    // R9: repeated START after pointer, and in the middle of a data byte
    bus_start(); send_byte(8'h26, 1, "R9 addr"); send_byte(8'h11, 1, "R9 ptr");
    bus_start(); send_byte(8'h27, 1, "R9 read after restart");
    push_exp(8'h3C, "R9 read via repeated start");
    recv_byte(1); bus_stop();
    bus_start(); send_byte(8'h26, 1, "R9 addr b"); send_byte(8'h12, 1, "R9 ptr b");
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
    bus_start(); send_byte(8'h27, 1, "R9 restart mid byte");
    push_exp(8'h7E, "R9 partial byte discarded");
    recv_byte(1); bus_stop();

    // R2: new strap value moves the address
    strap = 3'b101;
    repeat (5) @(negedge clk);
    bus_start(); send_byte(8'h26, 0, "R2 old address rejected"); bus_stop();
    bus_start(); send_byte(8'h2A, 1, "R2 strapped address"); send_byte(8'h10, 1, "R2 ptr"); bus_stop();
    bus_start(); send_byte(8'h2B, 1, "R2 strapped read");
    push_exp(8'hA5, "R2 read with new strap");
    recv_byte(1); bus_stop();

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule